// File: doc/BRIEF.md
# Command Response Buffer Controller

This block is the device side of a command/response buffer interface for a trusted security module, sitting on a simple memory-mapped bus. Software first asks for access and waits until the block reports that access is granted. It then walks the block through a fixed lifecycle. It requests readiness, fills the shared byte buffer with a command, and writes a start bit. It waits for the block to drop that bit, reads the response from the same buffer, and finally sends the block back to idle.

Three software-written bits are cleared by the hardware itself: the readiness request, the idle request and the start bit. They move the block through its phases: Idle, Ready, Reception, Execution and Completion. Execution is done by a stub engine. It keeps start high for a programmable number of cycles and then writes a fixed 10-byte response header into the buffer. The command/response address and size registers can be read and written by software and have no further effect.

Bus: `bus_wr`/`bus_rd` single-cycle strobes with `bus_addr`. Register reads return `bus_rdata` on the cycle after the strobe. Buffer bytes sit at `0x800 + index` and use `bus_wdata[7:0]`. A buffer read returns the byte zero-extended.

Top module: `crb_ctrl`

## Requirements
- R1: Writing a 1 to bit 0 of the access-control register (offset 0x004) sets bit 0 of the access-status register (offset 0x008) one cycle later. Writing a 1 to bit 1 of the access-control register clears it again.
- R2: Writing a 1 to bit 0 (ready request) of the request register (0x010) moves the block to Ready on the next cycle, from Idle or Completion. The hardware then clears the bit, and bit 0 (idle flag) of the status register (0x014) reads 0. A ready request written during Execution is ignored.
- R3: Writing a 1 to bit 1 (idle request) of the request register returns the block to Idle on the next cycle. The hardware clears the bit and the idle flag reads 1. An idle request written during Execution is ignored.
- R4: A 1 written to bit 0 of the start register (0x018) is accepted only when access is granted and the block is in Ready or Reception. Otherwise start keeps reading 0.
- R5: Once start is accepted, it stays at 1 for at least the number of cycles held in the latency register (0x01C) before the block clears it and enters Completion. When start clears, buffer bytes 0 to 9 hold 80 01 00 00 00 0A 00 00 00 00. This is a 2-byte tag, a 4-byte size of 10 and a 4-byte success code of zero, each field most-significant byte first.
- R6: While start is 1, bus writes to the buffer are discarded and buffer reads return 0.
- R7: The buffer holds 1280 bytes, at indices 0x000 to 0x4FF. Outside Execution, a byte written to any index reads back unchanged.
- R8: The identity register (offset 0x000) reads the configured identity word, and its low byte is never 0xFF.
- R9: The command high-address (0x020), command low-address (0x024), command size (0x028), response address (0x02C) and response size (0x030) registers each read back the full 32-bit value last written.
- R10: After reset, the idle flag reads 1, access is not granted, and the start, ready-request and idle-request bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after bus_rd |

## Verification
The full lifecycle is run with several execution latencies, including zero and a long one. Each run shows whether start is held for the programmed time and whether the header lands at the right byte positions with the right byte order. Start writes are tried in Idle, in Ready without access granted, and in Ready with access granted. These separate the grant gate from the phase gate. Buffer accesses are made during Execution at an index outside the header, so a discarded write can be told apart from a header write, and the buffer ends are exercised. Idle requests during Execution show that the self-clearing request bits are gated by phase.

// File: rtl/crb_pkg.sv
package crb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READY = 3'd1,
      PH_RECV  = 3'd2,
      PH_EXEC  = 3'd3,
      PH_DONE  = 3'd4
   } crb_phase_e;

   localparam int OFS_ID      = 'h000;
   localparam int OFS_LOC_CTL = 'h004;
   localparam int OFS_LOC_STS = 'h008;
   localparam int OFS_REQ     = 'h010;
   localparam int OFS_STS     = 'h014;
   localparam int OFS_START   = 'h018;
   localparam int OFS_LAT     = 'h01C;
   localparam int OFS_XFER0   = 'h020;
   localparam int NUM_XFER    = 5;

   localparam int HDR_LEN     = 10;

endpackage

// File: rtl/crb_locality.sv
module crb_locality (
   input  logic clk,
   input  logic rst_n,
   input  logic req_access,
   input  logic relinquish,
   output logic granted
);

   logic granted_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         granted_q <= 1'b0;
      end else if (relinquish) begin
         granted_q <= 1'b0;
      end else if (req_access) begin
         granted_q <= 1'b1;
      end
   end

   assign granted = granted_q;

endmodule

// File: rtl/crb_lifecycle.sv
module crb_lifecycle
   import crb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       granted,
   input  logic       req_cmd_ready,
   input  logic       req_go_idle,
   input  logic       req_start,
   input  logic       buf_wr_acc,
   input  logic       exec_done,
   output crb_phase_e phase,
   output logic       start_q,
   output logic       cmd_ready_q,
   output logic       go_idle_q,
   output logic       start_acc
);

   crb_phase_e phase_q;
   logic       in_exec;
   logic       phase_ok;

   assign in_exec  = (phase_q == PH_EXEC);
   assign phase_ok = (phase_q == PH_READY) || (phase_q == PH_RECV);

   assign start_acc = req_start && granted && phase_ok && !cmd_ready_q && !go_idle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_ready_q <= 1'b0;
         go_idle_q   <= 1'b0;
      end else begin
         if (cmd_ready_q) begin
            cmd_ready_q <= 1'b0;
         end else if (req_cmd_ready && !in_exec) begin
            cmd_ready_q <= 1'b1;
         end
         if (go_idle_q) begin
            go_idle_q <= 1'b0;
         end else if (req_go_idle && !in_exec) begin
            go_idle_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
      end else if (start_acc) begin
         start_q <= 1'b1;
      end else if (exec_done) begin
         start_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (in_exec) begin
         if (exec_done) begin
            phase_q <= PH_DONE;
         end
      end else if (go_idle_q) begin
         phase_q <= PH_IDLE;
      end else if (cmd_ready_q) begin
         phase_q <= PH_READY;
      end else if (start_acc) begin
         phase_q <= PH_EXEC;
      end else if (phase_q == PH_READY && buf_wr_acc) begin
         phase_q <= PH_RECV;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/crb_exec_stub.sv
module crb_exec_stub
   import crb_pkg::*;
#(
   parameter int          LAT_W    = 16,
   parameter int          IDX_W    = 11,
   parameter logic [15:0] RSP_TAG  = 16'h8001,
   parameter logic [31:0] RSP_CODE = 32'h0000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [LAT_W-1:0] latency,
   output logic             hdr_we,
   output logic [IDX_W-1:0] hdr_idx,
   output logic [7:0]       hdr_byte,
   output logic             done
);

   localparam int HDR_BITS = 8 * HDR_LEN;
   localparam int CNT_W    = $clog2(HDR_LEN);
   localparam logic [HDR_BITS-1:0] HDR_VEC = {RSP_TAG, 32'(HDR_LEN), RSP_CODE};

   logic [7:0]       hdr_rom [HDR_LEN];
   logic             busy_q;
   logic             hdr_q;
   logic [LAT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx_q;

   for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
      assign hdr_rom[g] = HDR_VEC[HDR_BITS-1-8*g -: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         hdr_q  <= 1'b0;
         cnt_q  <= '0;
         idx_q  <= '0;
      end else if (go) begin
         busy_q <= 1'b1;
         hdr_q  <= 1'b0;
         cnt_q  <= latency;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (!hdr_q) begin
            if (cnt_q == '0) begin
               hdr_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end else if (idx_q == CNT_W'(HDR_LEN - 1)) begin
            busy_q <= 1'b0;
            hdr_q  <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign hdr_we   = busy_q && hdr_q;
   assign hdr_idx  = IDX_W'(idx_q);
   assign hdr_byte = hdr_rom[idx_q];
   assign done     = hdr_we && (idx_q == CNT_W'(HDR_LEN - 1));

endmodule

// File: rtl/crb_databuf.sv
module crb_databuf #(
   parameter int BUF_BYTES = 1280,
   parameter int IDX_W     = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic             bus_re,
   input  logic             blank,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic [7:0]       bus_wbyte,
   input  logic             int_we,
   input  logic [IDX_W-1:0] int_idx,
   input  logic [7:0]       int_byte,
   output logic [7:0]       rbyte
);

   logic [7:0] mem [BUF_BYTES];
   logic [7:0] rbyte_q;

   always_ff @(posedge clk) begin
      if (int_we) begin
         mem[int_idx] <= int_byte;
      end else if (bus_we) begin
         mem[bus_idx] <= bus_wbyte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbyte_q <= '0;
      end else if (bus_re) begin
         rbyte_q <= blank ? 8'h00 : mem[bus_idx];
      end
   end

   assign rbyte = rbyte_q;

endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
   import crb_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                BUF_BYTES = 1280,
   parameter int                BUF_BASE  = 'h800,
   parameter int                LAT_W     = 16,
   parameter int                DEF_LAT   = 20,
   parameter logic [31:0]       DEV_ID    = 32'h0001_1A05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int BIDX_W = $clog2(BUF_BYTES);
   localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BUF_BASE);
   localparam logic [ADDR_W:0] END_X  = (ADDR_W+1)'(BUF_BASE + BUF_BYTES);

   if (DATA_W < 32) begin : g_chk_dw
      $error("DATA_W must be at least 32");
   end
   if (BUF_BASE + BUF_BYTES > (1 << ADDR_W)) begin : g_chk_aw
      $error("buffer window exceeds address space");
   end
   if (BUF_BASE <= OFS_XFER0 + 4 * NUM_XFER) begin : g_chk_base
      $error("buffer window overlaps registers");
   end
   if (DEV_ID[7:0] == 8'hFF) begin : g_chk_id
      $error("identity low byte must not be 0xFF");
   end
   if (LAT_W < 1 || DEF_LAT >= (1 << LAT_W)) begin : g_chk_lat
      $error("DEF_LAT does not fit LAT_W");
   end

   function automatic logic reg_at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // decode
   logic [ADDR_W:0]  addr_x;
   logic             buf_hit;
   logic [BIDX_W-1:0] buf_idx;

   assign addr_x  = {1'b0, bus_addr};
   assign buf_hit = (addr_x >= BASE_X) && (addr_x < END_X);
   assign buf_idx = BIDX_W'(addr_x - BASE_X);

   logic loc_req, loc_rel, req_cmd_ready, req_go_idle, req_start;
   assign loc_req       = bus_wr && reg_at(bus_addr, OFS_LOC_CTL) && bus_wdata[0];
   assign loc_rel       = bus_wr && reg_at(bus_addr, OFS_LOC_CTL) && bus_wdata[1];
   assign req_cmd_ready = bus_wr && reg_at(bus_addr, OFS_REQ) && bus_wdata[0];
   assign req_go_idle   = bus_wr && reg_at(bus_addr, OFS_REQ) && bus_wdata[1];
   assign req_start     = bus_wr && reg_at(bus_addr, OFS_START) && bus_wdata[0];

   // sub-blocks
   logic       loc_granted;
   crb_phase_e phase;
   logic       start_q, cmd_ready_q, go_idle_q, start_acc;
   logic       in_exec, buf_wr_acc;
   logic       exec_done, hdr_we;
   logic [BIDX_W-1:0] hdr_idx;
   logic [7:0] hdr_byte, buf_rbyte;
   logic [LAT_W-1:0] lat_q;

   assign in_exec    = (phase == PH_EXEC);
   assign buf_wr_acc = bus_wr && buf_hit && !in_exec;

   crb_locality u_loc (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_access (loc_req),
      .relinquish (loc_rel),
      .granted    (loc_granted)
   );

   crb_lifecycle u_life (
      .clk           (clk),
      .rst_n         (rst_n),
      .granted       (loc_granted),
      .req_cmd_ready (req_cmd_ready),
      .req_go_idle   (req_go_idle),
      .req_start     (req_start),
      .buf_wr_acc    (buf_wr_acc),
      .exec_done     (exec_done),
      .phase         (phase),
      .start_q       (start_q),
      .cmd_ready_q   (cmd_ready_q),
      .go_idle_q     (go_idle_q),
      .start_acc     (start_acc)
   );

   crb_exec_stub #(
      .LAT_W (LAT_W),
      .IDX_W (BIDX_W)
   ) u_exec (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (start_acc),
      .latency  (lat_q),
      .hdr_we   (hdr_we),
      .hdr_idx  (hdr_idx),
      .hdr_byte (hdr_byte),
      .done     (exec_done)
   );

   crb_databuf #(
      .BUF_BYTES (BUF_BYTES),
      .IDX_W     (BIDX_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (buf_wr_acc),
      .bus_re    (bus_rd && buf_hit),
      .blank     (in_exec),
      .bus_idx   (buf_idx),
      .bus_wbyte (bus_wdata[7:0]),
      .int_we    (hdr_we),
      .int_idx   (hdr_idx),
      .int_byte  (hdr_byte),
      .rbyte     (buf_rbyte)
   );

   // software registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q <= LAT_W'(DEF_LAT);
      end else if (bus_wr && reg_at(bus_addr, OFS_LAT)) begin
         lat_q <= bus_wdata[LAT_W-1:0];
      end
   end

   logic [DATA_W-1:0] xfer_q [NUM_XFER];

   for (genvar g = 0; g < NUM_XFER; g++) begin : g_xfer
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            xfer_q[g] <= '0;
         end else if (bus_wr && reg_at(bus_addr, OFS_XFER0 + 4 * g)) begin
            xfer_q[g] <= bus_wdata;
         end
      end
   end

   // read path
   logic [DATA_W-1:0] rd_mux, reg_rdata_q;
   logic              rd_buf_q;

   always_comb begin
      rd_mux = '0;
      if (reg_at(bus_addr, OFS_ID)) begin
         rd_mux = DATA_W'(DEV_ID);
      end else if (reg_at(bus_addr, OFS_LOC_STS)) begin
         rd_mux = DATA_W'(loc_granted);
      end else if (reg_at(bus_addr, OFS_REQ)) begin
         rd_mux = DATA_W'({go_idle_q, cmd_ready_q});
      end else if (reg_at(bus_addr, OFS_STS)) begin
         rd_mux = DATA_W'(phase == PH_IDLE);
      end else if (reg_at(bus_addr, OFS_START)) begin
         rd_mux = DATA_W'(start_q);
      end else if (reg_at(bus_addr, OFS_LAT)) begin
         rd_mux = DATA_W'(lat_q);
      end else begin
         for (int i = 0; i < NUM_XFER; i++) begin
            if (reg_at(bus_addr, OFS_XFER0 + 4 * i)) begin
               rd_mux = xfer_q[i];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata_q <= '0;
         rd_buf_q    <= 1'b0;
      end else if (bus_rd) begin
         reg_rdata_q <= rd_mux;
         rd_buf_q    <= buf_hit;
      end
   end

   assign bus_rdata = rd_buf_q ? DATA_W'(buf_rbyte) : reg_rdata_q;

endmodule

// File: rtl/crb_ctrl_chk.sv
module crb_ctrl_chk
   import crb_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int BUF_BYTES = 1280,
   parameter int BUF_BASE  = 'h800
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        wr_bits,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              granted,
   input crb_phase_e        phase,
   input logic              start_q,
   input logic              cmd_ready_q,
   input logic              go_idle_q
);

   logic rd_buf;
   assign rd_buf = bus_rd && (int'(bus_addr) >= BUF_BASE) && (int'(bus_addr) < BUF_BASE + BUF_BYTES);

   // R1
   p_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_LOC_CTL) && wr_bits == 2'b01) |=> granted);

   // R2
   p_ready_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready_q && !go_idle_q) |=> (!cmd_ready_q && phase == PH_READY));

   // R3
   p_go_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_idle_q |=> (!go_idle_q && phase == PH_IDLE));

   // R4
   p_start_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_q) |-> $past(granted));

   // R5
   p_start_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_q) |-> phase == PH_DONE);

   // R6
   p_exec_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_buf && phase == PH_EXEC) |=> bus_rdata == '0);

   // R8
   p_id_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_ID)) |=> bus_rdata[7:0] != 8'hFF);

endmodule

bind crb_ctrl crb_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BUF_BYTES (BUF_BYTES),
   .BUF_BASE  (BUF_BASE)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .wr_bits     (bus_wdata[1:0]),
   .bus_rdata   (bus_rdata),
   .granted     (loc_granted),
   .phase       (phase),
   .start_q     (start_q),
   .cmd_ready_q (cmd_ready_q),
   .go_idle_q   (go_idle_q)
);

// File: tb/crb_ctrl_tb.sv
`timescale 1ns/1ps
module crb_ctrl_tb_top;

   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int BUFB   = 'h800;
   localparam logic [31:0] ID = 32'h0001_1A05;

   localparam int A_ID = 'h000, A_LCTL = 'h004, A_LSTS = 'h008, A_REQ = 'h010,
                  A_STS = 'h014, A_START = 'h018, A_LAT = 'h01C, A_XFER = 'h020;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   crb_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = ADDR_W'(a);
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_STS, d);   chk("R10 idle", d, 32'h1);
      rd(A_LSTS, d);  chk("R10 granted", d, 32'h0);
      rd(A_START, d); chk("R10 start", d, 32'h0);
      rd(A_REQ, d);   chk("R10 request bits", d, 32'h0);
   endtask

   task automatic t_ident();
      logic [31:0] d;
      rd(A_ID, d);
      chk("R8 identity", d, ID);
      chk("R8 low byte not FF", 32'(d[7:0] != 8'hFF), 32'h1);
   endtask

   task automatic t_start_gating();
      logic [31:0] d;
      wr(A_START, 32'h1);
      rd(A_START, d); chk("R4 start in idle", d, 32'h0);
      wr(A_REQ, 32'h1);
      rd(A_REQ, d);   chk("R2 ready self-clear", d, 32'h0);
      rd(A_STS, d);   chk("R2 idle flag cleared", d, 32'h0);
      wr(A_START, 32'h1);
      rd(A_START, d); chk("R4 start without grant", d, 32'h0);
      wr(A_REQ, 32'h2);
      rd(A_REQ, d);   chk("R3 idle self-clear", d, 32'h0);
      rd(A_STS, d);   chk("R3 idle flag set", d, 32'h1);
   endtask

   task automatic t_locality();
      logic [31:0] d;
      wr(A_LCTL, 32'h1);
      rd(A_LSTS, d); chk("R1 granted", d, 32'h1);
      wr(A_LCTL, 32'h2);
      rd(A_LSTS, d); chk("R1 relinquished", d, 32'h0);
      wr(A_LCTL, 32'h1);
      rd(A_LSTS, d); chk("R1 granted again", d, 32'h1);
      wr(A_START, 32'h1);
      rd(A_START, d); chk("R4 start in idle with grant", d, 32'h0);
   endtask

   task automatic t_xfer_regs();
      logic [31:0] d;
      for (int i = 0; i < 5; i++) wr(A_XFER + 4 * i, 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1)));
      for (int i = 0; i < 5; i++) begin
         rd(A_XFER + 4 * i, d);
         chk("R9 transfer register", d, 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1)));
      end
   endtask

   task automatic t_buffer_ends();
      logic [31:0] d;
      wr(A_REQ, 32'h1);
      wr(BUFB + 0, 32'h3C);
      wr(BUFB + 'h4FF, 32'hE7);
      wr(BUFB + 'h27F, 32'h19);
      rd(BUFB + 0, d);     chk("R7 first byte", d, 32'h3C);
      rd(BUFB + 'h4FF, d); chk("R7 last byte", d, 32'hE7);
      rd(BUFB + 'h27F, d); chk("R7 middle byte", d, 32'h19);
      wr(A_REQ, 32'h2);
   endtask

   task automatic t_command(input int lat);
      logic [31:0] d;
      logic [7:0] hdr [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00};
      int t0, polls;
      wr(A_LAT, 32'(lat));
      wr(A_REQ, 32'h1);
      for (int i = 0; i < 10; i++) wr(BUFB + i, 32'h50 + i);
      wr(BUFB + 20, 32'h33);
      t0 = cyc;
      wr(A_START, 32'h1);
      rd(A_START, d); chk("R4 start accepted", d, 32'h1);
      if (d == 32'h1) begin
         rd(BUFB + 1, d);  chk("R6 read during execution", d, 32'h0);
         wr(BUFB + 20, 32'hCC);
         wr(A_REQ, 32'h2);
      end
      polls = 0;
      do begin
         rd(A_START, d);
         polls++;
      end while (d != 32'h0 && polls < 5000);
      chk("R5 start cleared", d, 32'h0);
      chk("R5 start held for latency", 32'((cyc - t0) > lat), 32'h1);
      rd(A_STS, d); chk("R3 idle request ignored in execution", d, 32'h0);
      for (int i = 0; i < 10; i++) begin
         rd(BUFB + i, d);
         chk("R5 header byte", d, 32'(hdr[i]));
      end
      rd(BUFB + 20, d); chk("R6 write discarded in execution", d, 32'h33);
      wr(A_REQ, 32'h1);
      rd(A_STS, d); chk("R2 ready from completion", d, 32'h0);
      wr(A_REQ, 32'h2);
      rd(A_STS, d); chk("R3 back to idle", d, 32'h1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ident();
      t_start_gating();
      t_locality();
      t_xfer_regs();
      t_buffer_ends();
      t_command(5);
      t_command(0);
      t_command(40);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule